// File: doc/BRIEF.md
# PCIe-to-AXI Request Bridge

This block sits behind a PCIe endpoint's receive path and turns inbound memory requests into AXI4 master transactions. Each request arrives as a simplified packet: a header on one valid/ready channel and, for writes, a payload on a second valid/ready channel. The header's PCIe address is moved into the AXI address space through one fixed window. A write becomes one AXI write burst whose first and last strobes come from the header's byte-enable fields. A read becomes one AXI read burst. Every returned AXI read beat is sent back as a single-beat completion packet. That packet carries the requester's ID and tag, the number of bytes still owed and the low address bits.

The block handles one header at a time. It does not accept another header until the current write's AW and all of its data beats have been transferred, or until the current read's AR has been issued. Write responses and read data are tracked separately. Several writes can wait for their B response at the same time, and several reads can wait for data. Each kind has its own limit. The write limit scales with the AXI data width.

Top module: `pcie_req_axi_master`

## Requirements
- R1: An accepted write header produces one AW transfer with the translated address, `m_awlen` equal to `hdr_len` (beats minus one), `m_awsize` equal to log2(DATA_W/8) and `m_awburst` = 2'b01 (INCR). AW fields hold steady while AW is stalled.
- R2: The AXI address is (hdr_addr − PCIE_BASE + AXI_BASE) modulo 2^AXI_AW. Header addresses are aligned to DATA_W/8 bytes.
- R3: A write's payload beats appear on W in arrival order, with `m_wdata` equal to `pl_data`. `m_wlast` is set on beat number `hdr_len`, and the payload channel moves only together with W.
- R4: The first W beat uses `hdr_first_be` as its strobe. The last beat uses `hdr_last_be`. Middle beats use all ones. A single-beat write uses `hdr_first_be` only.
- R5: At most DATA_W/16 writes may be waiting for their B response (4, 8, 16 or 32 for 64, 128, 256 or 512 bits). While that many are waiting, `hdr_ready` is low for a write header. A B response frees one slot.
- R6: An accepted read header produces one AR transfer carrying the translated address, `hdr_len`, the beat size and INCR burst. AR fields hold steady while AR is stalled.
- R7: At most RD_MAX (8) reads may have data still owed. While that many are owed, `hdr_ready` is low for a read header. The last R beat of a read frees one slot.
- R8: Each R beat becomes one completion with `cpl_data` equal to `m_rdata`, carrying the owning read's `hdr_req_id` and `hdr_tag`. Completions come out in read order, and R moves only when the completion does.
- R9: `cpl_byte_count` is (beats still owed for that read, including this one) × DATA_W/8. `cpl_lower_addr` is bits 6:0 of the read's PCIe address plus DATA_W/8 per beat already returned, modulo 128.
- R10: `cpl_status` is 3'b100 when `m_rresp` is 2'b10 or 2'b11, and 3'b000 when it is 2'b00 or 2'b01.
- R11: After reset, AW, AR, W and completion valids are low and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Request header valid |
| hdr_ready | output | 1 | Request header accepted |
| hdr_is_write | input | 1 | 1 = memory write, 0 = memory read |
| hdr_addr | input | PCIE_AW | PCIe byte address |
| hdr_len | input | 8 | Beats minus one |
| hdr_first_be | input | DATA_W/8 | Byte enables of first beat |
| hdr_last_be | input | DATA_W/8 | Byte enables of last beat |
| hdr_req_id | input | 16 | Requester ID |
| hdr_tag | input | 8 | Request tag |
| pl_valid | input | 1 | Write payload beat valid |
| pl_ready | output | 1 | Write payload beat taken |
| pl_data | input | DATA_W | Write payload beat |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion taken |
| cpl_data | output | DATA_W | Completion data |
| cpl_status | output | 3 | 000 success, 100 abort |
| cpl_req_id | output | 16 | Requester ID echoed |
| cpl_tag | output | 8 | Tag echoed |
| cpl_byte_count | output | 9+log2(DATA_W/8) | Bytes still owed |
| cpl_lower_addr | output | 7 | Low address of this beat |
| m_awvalid | output | 1 | AXI write address valid |
| m_awready | input | 1 | AXI write address ready |
| m_awaddr | output | AXI_AW | AXI write address |
| m_awlen | output | 8 | AXI write burst length |
| m_awsize | output | 3 | AXI write beat size |
| m_awburst | output | 2 | AXI write burst type |
| m_wvalid | output | 1 | AXI write data valid |
| m_wready | input | 1 | AXI write data ready |
| m_wdata | output | DATA_W | AXI write data |
| m_wstrb | output | DATA_W/8 | AXI write strobes |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | AXI write response valid |
| m_bready | output | 1 | AXI write response ready |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_araddr | output | AXI_AW | AXI read address |
| m_arlen | output | 8 | AXI read burst length |
| m_arsize | output | 3 | AXI read beat size |
| m_arburst | output | 2 | AXI read burst type |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |
| m_rdata | input | DATA_W | AXI read data |
| m_rresp | input | 2 | AXI read response |
| m_rlast | input | 1 | Last read beat |

## Verification
The bound checker watches the port-level quantities on every cycle. It keeps its own counts of writes waiting for B and reads owed data, and it flags any header accepted while the matching count is at its limit. It also flags AW or AR fields that change while the channel is stalled, and any completion that appears with no read outstanding. Other behaviours are visible only through the bench's scenarios: the address window arithmetic, the strobe pattern across single-beat and multi-beat bursts, and the byte-count and low-address sequence of each completion. So are the mapping from error responses to status, and the release of a stalled header once a B response or a final R beat arrives.

// File: rtl/pcie_req_axi_master.sv
module pcie_req_axi_master #(
  parameter int DATA_W = 64,
  parameter int AXI_AW = 32,
  parameter int PCIE_AW = 64,
  parameter int RD_MAX = 8,
  parameter logic [PCIE_AW-1:0] PCIE_BASE = 64'h0000_00A0_0000_0000,
  parameter logic [AXI_AW-1:0] AXI_BASE = 32'h8000_0000,
  localparam int STRB_W = DATA_W / 8,
  localparam int SIZE = $clog2(STRB_W),
  localparam int WR_MAX = DATA_W / 16,
  localparam int BCW = 9 + SIZE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hdr_valid,
  output logic               hdr_ready,
  input  logic               hdr_is_write,
  input  logic [PCIE_AW-1:0] hdr_addr,
  input  logic [7:0]         hdr_len,
  input  logic [STRB_W-1:0]  hdr_first_be,
  input  logic [STRB_W-1:0]  hdr_last_be,
  input  logic [15:0]        hdr_req_id,
  input  logic [7:0]         hdr_tag,
  input  logic               pl_valid,
  output logic               pl_ready,
  input  logic [DATA_W-1:0]  pl_data,
  output logic               cpl_valid,
  input  logic               cpl_ready,
  output logic [DATA_W-1:0]  cpl_data,
  output logic [2:0]         cpl_status,
  output logic [15:0]        cpl_req_id,
  output logic [7:0]         cpl_tag,
  output logic [BCW-1:0]     cpl_byte_count,
  output logic [6:0]         cpl_lower_addr,
  output logic               m_awvalid,
  input  logic               m_awready,
  output logic [AXI_AW-1:0]  m_awaddr,
  output logic [7:0]         m_awlen,
  output logic [2:0]         m_awsize,
  output logic [1:0]         m_awburst,
  output logic               m_wvalid,
  input  logic               m_wready,
  output logic [DATA_W-1:0]  m_wdata,
  output logic [STRB_W-1:0]  m_wstrb,
  output logic               m_wlast,
  input  logic               m_bvalid,
  output logic               m_bready,
  output logic               m_arvalid,
  input  logic               m_arready,
  output logic [AXI_AW-1:0]  m_araddr,
  output logic [7:0]         m_arlen,
  output logic [2:0]         m_arsize,
  output logic [1:0]         m_arburst,
  input  logic               m_rvalid,
  output logic               m_rready,
  input  logic [DATA_W-1:0]  m_rdata,
  input  logic [1:0]         m_rresp,
  input  logic               m_rlast
);
  localparam int WCW = $clog2(WR_MAX + 1);
  localparam int RCW = $clog2(RD_MAX + 1);
  localparam int PW  = $clog2(RD_MAX);

  typedef enum logic [1:0] {S_IDLE, S_AW, S_W, S_AR} st_t;
  st_t st;

  logic [AXI_AW-1:0] addr_q;
  logic [7:0]        len_q, beat_q, r_beat;
  logic [STRB_W-1:0] fbe_q, lbe_q;
  logic [WCW-1:0]    wr_cnt;
  logic [RCW-1:0]    rd_cnt;
  logic [PW-1:0]     wp, rp;
  logic [6:0]        la_off;
  logic [8:0]        left;

  logic [15:0] f_id  [RD_MAX];
  logic [7:0]  f_tag [RD_MAX];
  logic [6:0]  f_la  [RD_MAX];
  logic [7:0]  f_len [RD_MAX];

  wire hdr_fire  = hdr_valid & hdr_ready;
  wire aw_fire   = m_awvalid & m_awready;
  wire w_fire    = m_wvalid & m_wready;
  wire r_fire    = m_rvalid & cpl_ready;
  wire last_beat = beat_q == len_q;

  assign hdr_ready = (st == S_IDLE) &&
                     (hdr_is_write ? wr_cnt < WCW'(WR_MAX) : rd_cnt < RCW'(RD_MAX));

  assign m_awvalid = st == S_AW;
  assign m_arvalid = st == S_AR;
  assign m_awaddr  = addr_q;
  assign m_araddr  = addr_q;
  assign m_awlen   = len_q;
  assign m_arlen   = len_q;
  assign m_awsize  = 3'(SIZE);
  assign m_arsize  = 3'(SIZE);
  assign m_awburst = 2'b01;
  assign m_arburst = 2'b01;

  assign m_wvalid = (st == S_W) & pl_valid;
  assign pl_ready = (st == S_W) & m_wready;
  assign m_wdata  = pl_data;
  assign m_wlast  = (st == S_W) & last_beat;
  assign m_wstrb  = (beat_q == 8'd0) ? fbe_q : (last_beat ? lbe_q : '1);
  assign m_bready = 1'b1;

  assign m_rready       = cpl_ready;
  assign cpl_valid      = m_rvalid;
  assign cpl_data       = m_rdata;
  assign cpl_status     = (m_rresp >= 2'b10) ? 3'b100 : 3'b000;
  assign cpl_req_id     = f_id[rp];
  assign cpl_tag        = f_tag[rp];
  assign left           = 9'(f_len[rp]) + 9'd1 - 9'(r_beat);
  assign cpl_byte_count = BCW'(left) << SIZE;
  assign cpl_lower_addr = f_la[rp] + la_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      beat_q <= '0;
      wr_cnt <= '0;
      rd_cnt <= '0;
      wp     <= '0;
      rp     <= '0;
      r_beat <= '0;
      la_off <= '0;
    end else begin
      wr_cnt <= wr_cnt + WCW'(aw_fire) - WCW'(m_bvalid);
      rd_cnt <= rd_cnt + RCW'(hdr_fire & ~hdr_is_write) - RCW'(r_fire & m_rlast);
      case (st)
        S_IDLE: if (hdr_fire) begin
          st     <= hdr_is_write ? S_AW : S_AR;
          beat_q <= '0;
        end
        S_AW: if (m_awready) st <= S_W;
        S_W: if (w_fire) begin
          beat_q <= beat_q + 8'd1;
          if (last_beat) st <= S_IDLE;
        end
        S_AR: if (m_arready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (hdr_fire && !hdr_is_write) wp <= wp + PW'(1);
      if (r_fire) begin
        if (m_rlast) begin
          rp     <= rp + PW'(1);
          r_beat <= '0;
          la_off <= '0;
        end else begin
          r_beat <= r_beat + 8'd1;
          la_off <= la_off + 7'(STRB_W);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hdr_fire) begin
      addr_q <= AXI_AW'(hdr_addr - PCIE_BASE) + AXI_BASE;
      len_q  <= hdr_len;
      fbe_q  <= hdr_first_be;
      lbe_q  <= hdr_last_be;
      if (!hdr_is_write) begin
        f_id[wp]  <= hdr_req_id;
        f_tag[wp] <= hdr_tag;
        f_la[wp]  <= hdr_addr[6:0];
        f_len[wp] <= hdr_len;
      end
    end
  end
endmodule

// File: rtl/pcie_req_axi_master_chk.sv
module pcie_req_axi_master_chk #(
  parameter int DATA_W = 64,
  parameter int RD_MAX = 8,
  parameter int AXI_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic              hdr_is_write,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [AXI_AW-1:0] m_awaddr,
  input logic [7:0]        m_awlen,
  input logic              m_bvalid,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [AXI_AW-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic              m_rlast,
  input logic              cpl_valid
);
  localparam int WR_MAX = DATA_W / 16;
  int wo, ro;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wo <= 0;
      ro <= 0;
    end else begin
      wo <= wo + int'(m_awvalid && m_awready) - int'(m_bvalid);
      ro <= ro + int'(m_arvalid && m_arready) - int'(m_rvalid && m_rready && m_rlast);
    end
  end

  assert_wr_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && hdr_is_write |-> wo < WR_MAX);

  assert_rd_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && !hdr_is_write |-> ro < RD_MAX);

  assert_aw_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));

  assert_ar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

  assert_cpl_owed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> ro > 0);
endmodule

bind pcie_req_axi_master pcie_req_axi_master_chk #(
  .DATA_W(DATA_W), .RD_MAX(RD_MAX), .AXI_AW(AXI_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .hdr_is_write(hdr_is_write), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_bvalid(m_bvalid),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
  .m_arlen(m_arlen), .m_rvalid(m_rvalid), .m_rready(m_rready),
  .m_rlast(m_rlast), .cpl_valid(cpl_valid)
);

// File: tb/pcie_req_axi_master_test.sv
module pcie_req_axi_master_test;
  localparam logic [63:0] PBASE = 64'h0000_00A0_0000_0000;
  localparam logic [31:0] ABASE = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic hdr_valid = 0, hdr_ready, hdr_is_write = 0;
  logic [63:0] hdr_addr = '0;
  logic [7:0] hdr_len = '0, hdr_tag = '0;
  logic [7:0] hdr_first_be = '0, hdr_last_be = '0;
  logic [15:0] hdr_req_id = '0;
  logic pl_valid = 0, pl_ready;
  logic [63:0] pl_data = '0;
  logic cpl_valid, cpl_ready = 0;
  logic [63:0] cpl_data;
  logic [2:0] cpl_status;
  logic [15:0] cpl_req_id;
  logic [7:0] cpl_tag;
  logic [11:0] cpl_byte_count;
  logic [6:0] cpl_lower_addr;
  logic m_awvalid, m_awready = 0;
  logic [31:0] m_awaddr, m_araddr;
  logic [7:0] m_awlen, m_arlen;
  logic [2:0] m_awsize, m_arsize;
  logic [1:0] m_awburst, m_arburst;
  logic m_wvalid, m_wready = 0, m_wlast;
  logic [63:0] m_wdata;
  logic [7:0] m_wstrb;
  logic m_bvalid = 0, m_bready;
  logic m_arvalid, m_arready = 0;
  logic m_rvalid = 0, m_rready, m_rlast = 0;
  logic [63:0] m_rdata = '0;
  logic [1:0] m_rresp = '0;

  pcie_req_axi_master uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, bhold = 0, rhold = 0;
  logic [63:0] pl_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // AXI slave and payload source
  initial begin : slave
    logic [31:0] arq_a[$];
    logic [7:0]  arq_l[$];
    int rb = 0, bpend = 0;
    bit plf = 0, rf = 0;
    forever begin
      @(negedge clk);
      if (plf) void'(pl_q.pop_front());
      if (rf) begin
        if (rb == int'(arq_l[0])) begin
          void'(arq_a.pop_front()); void'(arq_l.pop_front()); rb = 0;
        end else rb++;
      end
      if (m_bvalid) bpend--;
      m_awready = $urandom_range(0, 3) != 0;
      m_wready  = $urandom_range(0, 3) != 0;
      m_arready = $urandom_range(0, 3) != 0;
      cpl_ready = $urandom_range(0, 3) != 0;
      m_bvalid  = bpend > 0 && !bhold && $urandom_range(0, 1) == 1;
      pl_valid  = pl_q.size() > 0 && $urandom_range(0, 4) != 0;
      pl_data   = pl_q.size() > 0 ? pl_q[0] : 64'h0;
      m_rvalid  = arq_a.size() > 0 && !rhold && $urandom_range(0, 3) != 0;
      if (arq_a.size() > 0) begin
        m_rdata = {arq_a[0] + 32'(rb * 8), 32'hC0DE_0000 | 32'(rb)};
        m_rlast = rb == int'(arq_l[0]);
        m_rresp = arq_a[0][9] ? 2'b11 : (arq_a[0][8] && rb == 1) ? 2'b10 :
                  arq_a[0][10] ? 2'b01 : 2'b00;
      end
      #1;
      plf = pl_valid && pl_ready;
      rf  = m_rvalid && m_rready;
      if (m_arvalid && m_arready) begin arq_a.push_back(m_araddr); arq_l.push_back(m_arlen); end
      if (m_wvalid && m_wready && m_wlast) bpend++;
    end
  end

  // Behavioural reference model, compared every clock
  int mst = 0, wbeat = 0, wout = 0, mbeat = 0;
  logic [31:0] e_addr; logic [7:0] e_len, e_fbe, e_lbe;
  logic [15:0] q_id[$]; logic [7:0] q_tag[$], q_len[$]; logic [6:0] q_la[$];

  initial begin : monitor
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        chk(hdr_ready == (mst == 0 && (hdr_is_write ? wout < 4 : q_id.size() < 8)),
            hdr_is_write ? "R5" : "R7", "hdr_ready", longint'(hdr_ready), 0);
        chk(m_awvalid == (mst == 1), "R1", "awvalid", longint'(m_awvalid), mst);
        chk(m_arvalid == (mst == 3), "R6", "arvalid", longint'(m_arvalid), mst);
        chk(m_wvalid == (mst == 2 && pl_valid) && pl_ready == (mst == 2 && m_wready),
            "R3", "wvalid/pl_ready", longint'({m_wvalid, pl_ready}), mst);
        chk(m_rready == cpl_ready, "R8", "rready", longint'(m_rready), longint'(cpl_ready));
        if (m_awvalid && m_awready) begin
          chk(m_awaddr == e_addr, "R2", "awaddr", m_awaddr, e_addr);
          chk(m_awlen == e_len && m_awsize == 3 && m_awburst == 1, "R1", "aw len/size/burst",
              longint'({m_awlen, m_awsize, m_awburst}), longint'({e_len, 3'd3, 2'd1}));
          wout++; mst = 2; wbeat = 0;
        end
        if (m_arvalid && m_arready) begin
          chk(m_araddr == e_addr, "R2", "araddr", m_araddr, e_addr);
          chk(m_arlen == e_len && m_arsize == 3 && m_arburst == 1, "R6", "ar len/size/burst",
              longint'({m_arlen, m_arsize, m_arburst}), longint'({e_len, 3'd3, 2'd1}));
          mst = 0;
        end
        if (m_wvalid && m_wready) begin
          logic [7:0] es;
          es = (wbeat == 0) ? e_fbe : (wbeat == int'(e_len)) ? e_lbe : 8'hFF;
          chk(m_wstrb == es, "R4", "wstrb", m_wstrb, es);
          chk(m_wdata == pl_q[0], "R3", "wdata", m_wdata, pl_q[0]);
          chk(m_wlast == (wbeat == int'(e_len)), "R3", "wlast", m_wlast, wbeat);
          if (wbeat == int'(e_len)) mst = 0; else wbeat++;
        end
        if (m_bvalid) begin
          chk(m_bready == 1'b1, "R5", "bready", m_bready, 1); wout--;
        end
        if (cpl_valid && cpl_ready) begin
          logic [11:0] ebc; logic [6:0] ela; logic [2:0] est;
          ebc = 12'((int'(q_len[0]) + 1 - mbeat) * 8);
          ela = q_la[0] + 7'(mbeat * 8);
          est = (m_rresp >= 2'b10) ? 3'b100 : 3'b000;
          chk(cpl_data == m_rdata && cpl_req_id == q_id[0] && cpl_tag == q_tag[0], "R8",
              "cpl data/id/tag", longint'({cpl_req_id, cpl_tag}), longint'({q_id[0], q_tag[0]}));
          chk(cpl_byte_count == ebc, "R9", "byte_count", cpl_byte_count, ebc);
          chk(cpl_lower_addr == ela, "R9", "lower_addr", cpl_lower_addr, ela);
          chk(cpl_status == est, "R10", "status", cpl_status, est);
          if (mbeat == int'(q_len[0])) begin
            void'(q_id.pop_front()); void'(q_tag.pop_front());
            void'(q_len.pop_front()); void'(q_la.pop_front()); mbeat = 0;
          end else mbeat++;
        end
        if (hdr_valid && hdr_ready) begin
          e_addr = 32'(hdr_addr - PBASE) + ABASE;
          e_len = hdr_len; e_fbe = hdr_first_be; e_lbe = hdr_last_be;
          if (hdr_is_write) mst = 1;
          else begin
            mst = 3;
            q_id.push_back(hdr_req_id); q_tag.push_back(hdr_tag);
            q_len.push_back(hdr_len); q_la.push_back(hdr_addr[6:0]);
          end
        end
      end
    end
  end

  task automatic send(input bit w, input logic [19:0] off, input logic [7:0] len,
                      input logic [7:0] fbe, input logic [7:0] lbe,
                      input logic [15:0] id, input logic [7:0] tag);
    if (w) for (int i = 0; i <= int'(len); i++) pl_q.push_back({$urandom, $urandom});
    @(negedge clk);
    hdr_is_write = w; hdr_addr = PBASE + 64'(off); hdr_len = len;
    hdr_first_be = fbe; hdr_last_be = lbe; hdr_req_id = id; hdr_tag = tag;
    hdr_valid = 1;
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (n < 5000 && !(mst == 0 && wout == 0 && q_id.size() == 0 && pl_q.size() == 0)) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    chk(!m_awvalid && !m_arvalid && !m_wvalid && !cpl_valid && hdr_ready, "R11",
        "reset outputs", longint'({m_awvalid, m_arvalid, m_wvalid, cpl_valid, hdr_ready}), 1);
    @(negedge clk); rst_n = 1;

    // R4 single beat, multi-beat strobes; R1/R2 translation
    send(1, 20'h00010, 8'd0, 8'h3C, 8'hFF, 16'h0100, 8'h01);
    send(1, 20'h12340, 8'd3, 8'hF0, 8'h0F, 16'h0100, 8'h02);
    send(1, 20'hFFFF8, 8'd7, 8'hFE, 8'h7F, 16'h0100, 8'h03);
    // R8/R9/R10 reads: success, exokay, slverr on beat 1, decerr throughout
    send(0, 20'h00048, 8'd3, 8'hFF, 8'hFF, 16'hBEEF, 8'h11);
    send(0, 20'h00470, 8'd1, 8'hFF, 8'hFF, 16'h1234, 8'h12);
    send(0, 20'h00178, 8'd2, 8'hFF, 8'hFF, 16'h0A0B, 8'h13);
    send(0, 20'h00200, 8'd0, 8'hFF, 8'hFF, 16'h0C0D, 8'h14);
    drain();

    // mixed traffic
    for (int k = 0; k < 30; k++)
      send($urandom_range(0, 1) == 1, 20'($urandom) & 20'hFFFF8, 8'($urandom_range(0, 5)),
           8'($urandom), 8'($urandom), 16'($urandom), 8'(k + 32));
    drain();

    // R5 write limit with responses held
    bhold = 1;
    fork
      for (int k = 0; k < 6; k++) send(1, 20'(k * 8), 8'd0, 8'hFF, 8'hFF, 16'h2, 8'(k));
      begin
        repeat (80) @(negedge clk); #1;
        chk(hdr_valid && !hdr_ready && wout == 4, "R5", "write stall at limit",
            longint'(hdr_ready), 0);
        bhold = 0;
      end
    join
    drain();

    // R7 read limit with data held
    rhold = 1;
    fork
      for (int k = 0; k < 10; k++) send(0, 20'(k * 64), 8'd1, 8'hFF, 8'hFF, 16'h3, 8'(k));
      begin
        repeat (80) @(negedge clk); #1;
        chk(hdr_valid && !hdr_ready && q_id.size() == 8, "R7", "read stall at limit",
            longint'(hdr_ready), 0);
        rhold = 0;
      end
    join
    drain();

    chk(pl_q.size() == 0, "R3", "payload fully consumed", pl_q.size(), 0);
    chk(q_id.size() == 0, "R8", "all completions returned", q_id.size(), 0);
    finish_run();
  end
endmodule